// File: doc/BRIEF.md
# Multi-master SPI controller

This block is a full-duplex synchronous serial controller that can act either as the clock-driving master or as a clocked slave. Bytes move most-significant bit first. The clock polarity (idle level) and the clock phase (whether a bit is sampled on the leading or the trailing edge) are set by configuration inputs. A host feeds transmit bytes through a valid/ready port and takes received bytes from a second valid/ready port. Each direction has a two-entry queue between the host and the shifter.

In master mode the serial clock comes from an 8-bit divider of the system clock. The slave-select pin has three uses. It can be unused (3-wire). It can be an active-low input, which selects the block when it is a slave and signals a mode fault when it is a master. It can be a chip-select output whose level the host sets. A mode fault disables master operation, releases the clock and data lines, and stays set until the host clears it.

In slave mode the pin inputs are synchronised to the system clock. A programmable timeout raises a sticky flag in two cases: when a partly shifted byte sees no clock edge for the set number of cycles, or when received data stays unread for that long.

Top module: `mmspi_ctrl`

## Requirements
- R1: After reset, tx_ready is 1, and rx_valid, mode_fault, tmo_flag, busy, sck_oe and mosi_oe are all 0.
- R2: In master mode, each queued byte is shifted out on mosi_o MSB first while a byte is shifted in from miso_i. This holds for all four combinations of cfg_cpol and cfg_cpha. With cfg_cpha=0 the sample is taken on the leading edge; with cfg_cpha=1 it is taken on the trailing edge. sck_o rests at cfg_cpol between bytes.
- R3: In master mode every half period of sck_o lasts cfg_div+1 system clock cycles, so one byte takes 16 half periods.
- R4: The transmit queue holds two bytes. With two bytes waiting and none consumed, tx_ready is 0.
- R5: The receive queue holds two bytes. A byte completed while it is full is discarded, and the two older bytes are read back in arrival order.
- R6: In slave mode, for all four clock modes, the block captures mosi_i on the sample edges of sck_i and drives the queued transmit byte on miso_o MSB first. When no byte is queued it sends 8'hFF.
- R7: In slave mode with cfg_nss_mode=1, nss_i high deselects the block. While deselected, miso_oe is 0 and sck_i edges are ignored. nss_i low selects the block and sets miso_oe to 1.
- R8: In master mode with cfg_nss_mode=1, nss_i driven low sets mode_fault. The block then drops sck_oe and mosi_oe and abandons the byte in flight, which is not delivered. mode_fault stays set after nss_i returns high, until fault_clr is pulsed.
- R9: With cfg_nss_mode=2 in master mode, nss_oe is 1 and nss_o follows cfg_cs_level. With cfg_nss_mode 0 or 2, nss_i low never sets mode_fault. Mode codes: 0 means no slave select, 1 means select/fault input, 2 means chip-select output.
- R10: In slave mode, a partly received byte that sees no sck_i edge for cfg_tmo cycles sets tmo_flag and clears the bit count, so the next eight sample edges form a whole byte.
- R11: In slave mode, a received byte left unread for cfg_tmo cycles sets tmo_flag. cfg_tmo=0 disables the timeout. tmo_clr clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 samples on the leading edge, 1 samples on the trailing edge |
| cfg_nss_mode | input | 2 | 0 none, 1 select/fault input, 2 chip-select output |
| cfg_cs_level | input | 1 | Level driven on nss_o in mode 2 |
| cfg_div | input | 8 | Clock divider; half period is cfg_div+1 cycles |
| cfg_tmo | input | 8 | Slave timeout in cycles; 0 disables it |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmit queue has room |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | Receive queue holds a byte |
| rx_ready | input | 1 | Host takes rx_data |
| fault_clr | input | 1 | Clears mode_fault |
| mode_fault | output | 1 | Sticky multi-master fault |
| tmo_clr | input | 1 | Clears tmo_flag |
| tmo_flag | output | 1 | Sticky slave timeout flag |
| busy | output | 1 | A byte is being shifted |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Master data in (slave) |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Slave data in (master) |
| nss_o | output | 1 | Chip-select output level |
| nss_oe | output | 1 | Chip-select output enable |
| nss_i | input | 1 | Slave-select / fault input, active low |

## Verification
The bench sweeps all four clock modes in both roles, and in master mode also several divider values. A wrong sample/drive edge choice would show up as a shifted or duplicated bit, and a divider that is off by one would show up as a measured half period that misses cfg_div+1. The phase-1 first-bit case gets attention because a shifter that moves on the first leading edge loses the MSB. The bench also checks that a mode fault in mid-byte suppresses delivery of that byte and stays sticky, since a design that only gates the pins would still push a corrupt byte. In the slave timeout case, a bit counter that is not cleared would misalign the next byte by the stalled bit count.

// File: rtl/mmspi_pkg.sv
package mmspi_pkg;

  localparam int SPI_W = 8;

  typedef enum logic [1:0] {
    NSS_NONE = 2'd0,
    NSS_IN   = 2'd1,
    NSS_OUT  = 2'd2
  } nss_mode_e;

  // shift one bit in at the LSB end
  function automatic logic [SPI_W-1:0] shl_in(input logic [SPI_W-1:0] d, input logic b);
    return {d[SPI_W-2:0], b};
  endfunction

  // phase 0 samples on the leading edge, phase 1 on the trailing edge
  function automatic logic is_sample(input logic lead, input logic cpha);
    return cpha ? !lead : lead;
  endfunction

endpackage

// File: rtl/mmspi_fifo.sv
module mmspi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R5
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> ($stable(cnt) && $stable(wp)));

endmodule

// File: rtl/mmspi_clkdiv.sv
module mmspi_clkdiv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R3
  half_period_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div != $past(div)));

endmodule

// File: rtl/mmspi_tmo.sv
module mmspi_tmo #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          kick,
  input  logic [TW-1:0] limit,
  output logic          hit
);
  logic [TW-1:0] cnt;

  assign hit = arm && !kick && (limit != '0) && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    cnt <= '0;
    else if (!arm || kick || hit || limit == '0)   cnt <= '0;
    else                                           cnt <= cnt + 1'b1;
  end

  // R11
  tmo_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && limit > TW'(1)) |=> !hit);

endmodule

// File: rtl/mmspi_ctrl.sv
module mmspi_ctrl
  import mmspi_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int TMO_W      = 8,
  parameter int FIFO_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic [1:0]       cfg_nss_mode,
  input  logic             cfg_cs_level,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [TMO_W-1:0] cfg_tmo,
  input  logic [SPI_W-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [SPI_W-1:0] rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  input  logic             fault_clr,
  output logic             mode_fault,
  input  logic             tmo_clr,
  output logic             tmo_flag,
  output logic             busy,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             sck_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             miso_i,
  output logic             nss_o,
  output logic             nss_oe,
  input  logic             nss_i
);
  localparam int HCW = $clog2(2 * SPI_W);
  localparam int BW  = $clog2(SPI_W);

  nss_mode_e nmode;
  assign nmode = nss_mode_e'(cfg_nss_mode);

  // ---- pin synchronisers: {nss, mosi, sck} ----
  logic [2:0] s1, s2;
  logic       sck_prev;
  logic [1:0] warm;
  logic       warm_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 3'b100; s2 <= 3'b100; sck_prev <= 1'b0; warm <= '0;
    end else begin
      s1 <= {nss_i, mosi_i, sck_i};
      s2 <= s1;
      sck_prev <= s2[0];
      if (warm != 2'd3) warm <= warm + 1'b1;
    end
  end
  assign warm_ok = (warm == 2'd3);

  // ---- queues ----
  logic             txq_pop, txq_full, txq_empty;
  logic [SPI_W-1:0] txq_rdata;
  logic             rx_push, rx_pop, rxq_full, rxq_empty;
  logic [SPI_W-1:0] rx_wdata;

  mmspi_fifo #(.W(SPI_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n, .push(tx_valid), .wdata(tx_data), .pop(txq_pop),
    .rdata(txq_rdata), .full(txq_full), .empty(txq_empty));

  mmspi_fifo #(.W(SPI_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n, .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .rdata(rx_data), .full(rxq_full), .empty(rxq_empty));

  assign tx_ready = !txq_full;
  assign rx_valid = !rxq_empty;
  assign rx_pop   = rx_ready && rx_valid;

  // ---- mode fault ----
  logic fault, fault_set, master_act;
  assign fault_set  = cfg_master && (nmode == NSS_IN) && !s2[2] && warm_ok;
  assign master_act = cfg_master && !fault;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault <= 1'b0;
    else if (fault_set) fault <= 1'b1;
    else if (fault_clr) fault <= 1'b0;
  end
  assign mode_fault = fault;

  // ---- master shifter ----
  logic             m_act, m_ph, m_tick, m_start, m_done;
  logic [HCW-1:0]   m_hc;
  logic [SPI_W-1:0] m_tx, m_rx;

  mmspi_clkdiv #(.DW(DIV_W)) u_div (
    .clk, .rst_n, .en(m_act), .div(cfg_div), .tick(m_tick));

  assign m_start = master_act && !m_act && !txq_empty;
  assign m_done  = master_act && m_act && m_tick && (m_hc == HCW'(2 * SPI_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 1'b0; m_ph <= 1'b0; m_hc <= '0; m_tx <= '1; m_rx <= '0;
    end else if (!master_act) begin
      m_act <= 1'b0; m_ph <= 1'b0; m_hc <= '0;
    end else if (m_start) begin
      m_act <= 1'b1; m_ph <= 1'b0; m_hc <= '0; m_tx <= txq_rdata;
    end else if (m_act && m_tick) begin
      m_ph <= ~m_ph;
      m_hc <= m_hc + 1'b1;
      if (is_sample(!m_hc[0], cfg_cpha)) m_rx <= shl_in(m_rx, miso_i);
      else if (m_hc != '0)               m_tx <= shl_in(m_tx, 1'b1);
      if (m_done) m_act <= 1'b0;
    end
  end

  // ---- slave shifter ----
  logic             slv_sel, s_edge, s_lead, s_sample, s_drive, s_done, s_load, s_need;
  logic             tmo_hit;
  logic [BW-1:0]    s_bit;
  logic [SPI_W-1:0] s_rx, s_tx;

  assign slv_sel  = !cfg_master && ((nmode == NSS_IN) ? !s2[2] : 1'b1);
  assign s_edge   = warm_ok && (s2[0] != sck_prev);
  assign s_lead   = (s2[0] != cfg_cpol);
  assign s_sample = slv_sel && s_edge && is_sample(s_lead, cfg_cpha);
  assign s_drive  = slv_sel && s_edge && !is_sample(s_lead, cfg_cpha);
  assign s_done   = s_sample && (s_bit == BW'(SPI_W - 1));
  assign s_load   = s_need && !txq_empty && !cfg_master && (s_bit == '0) && !s_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_bit <= '0; s_rx <= '0; s_tx <= '1; s_need <= 1'b1;
    end else begin
      if (!slv_sel || tmo_hit) s_bit <= '0;
      else if (s_sample) begin
        s_bit <= s_bit + 1'b1;
        s_rx  <= shl_in(s_rx, s2[1]);
      end
      if (s_done) begin
        s_tx <= '1; s_need <= 1'b1;
      end else if (s_load) begin
        s_tx <= txq_rdata; s_need <= 1'b0;
      end else if (s_drive && s_bit != '0) begin
        s_tx <= shl_in(s_tx, 1'b1);
      end
    end
  end

  // ---- slave timeout ----
  mmspi_tmo #(.TW(TMO_W)) u_tmo (
    .clk, .rst_n,
    .arm(!cfg_master && (s_bit != '0 || !rxq_empty)),
    .kick((slv_sel && s_edge) || rx_pop),
    .limit(cfg_tmo), .hit(tmo_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmo_flag <= 1'b0;
    else if (tmo_hit) tmo_flag <= 1'b1;
    else if (tmo_clr) tmo_flag <= 1'b0;
  end

  // ---- joins and pins ----
  assign txq_pop  = m_start || s_load;
  assign rx_push  = m_done || s_done;
  assign rx_wdata = m_done ? (cfg_cpha ? shl_in(m_rx, miso_i) : m_rx) : shl_in(s_rx, s2[1]);
  assign busy     = m_act || (s_bit != '0);
  assign sck_o    = cfg_cpol ^ m_ph;
  assign sck_oe   = master_act;
  assign mosi_o   = m_tx[SPI_W-1];
  assign mosi_oe  = master_act;
  assign miso_o   = s_tx[SPI_W-1];
  assign miso_oe  = slv_sel;
  assign nss_o    = cfg_cs_level;
  assign nss_oe   = master_act && (nmode == NSS_OUT);

  // R8
  fault_stops_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |=> !m_act);

  // R2
  idle_sck_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_act |-> (sck_o == cfg_cpol));

  // R10
  tmo_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (s_bit == '0));

  // R5
  rx_full_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxq_full && !rx_pop) |=> rxq_full);

endmodule

// File: tb/mmspi_ctrl_bench.sv
module mmspi_ctrl_bench;
  localparam int HP = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cfg_master = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_cs_level = 1'b0;
  logic [1:0] cfg_nss_mode = 2'd0;
  logic [7:0] cfg_div = 8'd0, cfg_tmo = 8'd0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_valid = 1'b0, rx_ready = 1'b0, fault_clr = 1'b0, tmo_clr = 1'b0;
  logic       sck_i = 1'b0, mosi_i = 1'b0, nss_i = 1'b1;
  logic       loopback = 1'b0;
  wire  [7:0] rx_data;
  wire        tx_ready, rx_valid, mode_fault, tmo_flag, busy;
  wire        sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, nss_o, nss_oe;
  wire        miso_i;

  // bench slave model (for master tests)
  logic [7:0] mdl_seed = 8'h00;
  logic       mdl_load = 1'b0;
  logic [7:0] mdl_tx, mdl_rx;
  logic       mdl_first, prev_sck;
  int         ecnt, bad_hp, te_prev, cyc;

  assign miso_i = loopback ? mosi_o : mdl_tx[7];

  mmspi_ctrl u_mmspi_ctrl (
    .clk, .rst_n, .cfg_master, .cfg_cpol, .cfg_cpha, .cfg_nss_mode, .cfg_cs_level,
    .cfg_div, .cfg_tmo, .tx_data, .tx_valid, .tx_ready, .rx_data, .rx_valid, .rx_ready,
    .fault_clr, .mode_fault, .tmo_clr, .tmo_flag, .busy, .sck_o, .sck_oe, .sck_i,
    .mosi_o, .mosi_oe, .mosi_i, .miso_o, .miso_oe, .miso_i, .nss_o, .nss_oe, .nss_i);

  always @(posedge clk) cyc <= cyc + 1;
  initial cyc = 0;

  initial begin
    mdl_tx = 8'hFF; mdl_rx = 8'h00; mdl_first = 1'b1; prev_sck = 1'b0;
    ecnt = 0; bad_hp = 0; te_prev = 0;
  end

  always @(negedge clk) begin
    if (mdl_load) begin
      mdl_tx = mdl_seed; mdl_rx = 8'h00; mdl_first = 1'b1; ecnt = 0; bad_hp = 0;
    end else if (sck_o != prev_sck) begin
      if (ecnt > 0 && (cyc - te_prev) != int'(cfg_div) + 1) bad_hp = bad_hp + 1;
      te_prev = cyc;
      ecnt = ecnt + 1;
      if (cfg_cpha ? (sck_o == cfg_cpol) : (sck_o != cfg_cpol))
        mdl_rx = {mdl_rx[6:0], mosi_o};
      else if (cfg_cpha && mdl_first) mdl_first = 1'b0;
      else mdl_tx = {mdl_tx[6:0], 1'b1};
    end
    prev_sck = sck_o;
  end

  int checks = 0, fails = 0;
  logic finished = 1'b0;

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_rx(input int lim);
    for (int i = 0; i < lim && !rx_valid; i++) @(negedge clk);
  endtask

  task automatic model_arm(input logic [7:0] seed);
    mdl_seed = seed; mdl_load = 1'b1;
    repeat (2) @(negedge clk);
    mdl_load = 1'b0;
  endtask

  task automatic master_xfer(input logic pol, input logic pha, input logic [7:0] dv,
                             input logic [7:0] txb, input logic [7:0] slb);
    cfg_master = 1'b1; cfg_cpol = pol; cfg_cpha = pha; cfg_div = dv;
    cfg_nss_mode = 2'd0; loopback = 1'b0;
    reset_dut();
    model_arm(slb);
    chk("R2 sck idle level", sck_o, pol);
    push(txb);
    wait_rx(40 * (int'(dv) + 1) + 20);
    repeat (2) @(negedge clk);
    chk("R2 master received byte", rx_data, slb);
    chk("R2 byte seen on mosi", mdl_rx, txb);
    chk("R3 edge count", ecnt, 16);
    chk("R3 half period", bad_hp, 0);
    pop();
  endtask

  task automatic bm_byte(input logic [7:0] mb, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      if (!cfg_cpha) begin
        mosi_i = mb[i];
        repeat (HP) @(negedge clk);
        sck_i = ~cfg_cpol; got[i] = miso_o;
        repeat (HP) @(negedge clk);
        sck_i = cfg_cpol;
      end else begin
        sck_i = ~cfg_cpol; mosi_i = mb[i];
        repeat (HP) @(negedge clk);
        sck_i = cfg_cpol; got[i] = miso_o;
        repeat (HP) @(negedge clk);
      end
    end
    repeat (HP) @(negedge clk);
  endtask

  task automatic slave_cfg(input logic pol, input logic pha, input logic four);
    cfg_master = 1'b0; cfg_cpol = pol; cfg_cpha = pha;
    cfg_nss_mode = four ? 2'd1 : 2'd0; cfg_tmo = 8'd0;
    sck_i = pol; mosi_i = 1'b0; nss_i = 1'b1;
    reset_dut();
  endtask

  initial begin
    logic [7:0] got;
    logic [7:0] a, b;
    // reset state
    reset_dut();
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 mode_fault", mode_fault, 0);
    chk("R1 tmo_flag", tmo_flag, 0);
    chk("R1 busy", busy, 0);
    chk("R1 sck_oe/mosi_oe", {sck_oe, mosi_oe}, 0);

    // master sweep: modes x dividers
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 3; d++) begin
        a = 8'h5A ^ 8'(m * 37 + d * 11);
        b = {a[3:0], ~a[7:4]} ^ 8'(d);
        master_xfer(m[1], m[0], 8'(d * d + d), a, b);
      end

    // R5: three bytes back to back, loopback, receive queue overflows
    cfg_master = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_div = 8'd1; cfg_nss_mode = 2'd0;
    loopback = 1'b1;
    reset_dut();
    push(8'hA1); push(8'hB2); push(8'hC3);
    repeat (3 * 16 * 2 + 40) @(negedge clk);
    chk("R5 first byte kept", rx_data, 8'hA1);
    pop();
    chk("R5 second byte kept", rx_data, 8'hB2);
    pop();
    chk("R5 third byte dropped", rx_valid, 0);
    loopback = 1'b0;

    // R8 mode fault mid byte, R4 queue depth while halted
    cfg_nss_mode = 2'd1; cfg_div = 8'd3; nss_i = 1'b1;
    reset_dut();
    model_arm(8'h3C);
    push(8'h96);
    repeat (20) @(negedge clk);
    nss_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 fault raised", mode_fault, 1);
    chk("R8 bus released", {sck_oe, mosi_oe}, 0);
    nss_i = 1'b1;
    repeat (200) @(negedge clk);
    chk("R8 aborted byte not delivered", rx_valid, 0);
    chk("R8 fault sticky", mode_fault, 1);
    push(8'h11); push(8'h22);
    chk("R4 tx queue full at two", tx_ready, 0);
    fault_clr = 1'b1; @(negedge clk); fault_clr = 1'b0;
    chk("R8 fault cleared", {mode_fault, sck_oe}, 1);

    // R9 chip-select output, nss_i ignored
    cfg_nss_mode = 2'd2; cfg_cs_level = 1'b0; nss_i = 1'b1;
    reset_dut();
    chk("R9 nss_oe", nss_oe, 1);
    chk("R9 nss_o low", nss_o, 0);
    cfg_cs_level = 1'b1; @(negedge clk);
    chk("R9 nss_o high", nss_o, 1);
    nss_i = 1'b0; repeat (10) @(negedge clk);
    chk("R9 no fault in cs mode", mode_fault, 0);
    cfg_nss_mode = 2'd0; repeat (10) @(negedge clk);
    chk("R9 no fault in 3-wire", {mode_fault, nss_oe}, 0);
    nss_i = 1'b1;

    // slave sweep: modes x 3/4 wire
    for (int m = 0; m < 8; m++) begin
      a = 8'hC5 ^ 8'(m * 29);
      b = 8'h3B ^ 8'(m * 53);
      slave_cfg(m[1], m[0], m[2]);
      push(a);
      repeat (3) @(negedge clk);
      if (m[2]) begin
        chk("R7 miso_oe off when deselected", miso_oe, 0);
        for (int k = 0; k < 6; k++) begin
          sck_i = ~sck_i; repeat (HP) @(negedge clk);
        end
        nss_i = 1'b0; repeat (4) @(negedge clk);
        chk("R7 miso_oe on when selected", miso_oe, 1);
      end
      bm_byte(b, got);
      chk("R6 slave received byte", rx_data, b);
      chk("R6 slave sent byte", got, a);
      pop();
      if (m == 7) begin
        bm_byte(8'h0F, got);
        chk("R6 empty queue sends ones", got, 8'hFF);
        chk("R7 deselected edges ignored", rx_data, 8'h0F);
        pop();
      end
      nss_i = 1'b1;
    end

    // R10 stalled partial byte, R11 unread data
    slave_cfg(1'b0, 1'b0, 1'b0);
    cfg_tmo = 8'd20;
    for (int k = 0; k < 3; k++) begin
      mosi_i = 1'b1;
      repeat (HP) @(negedge clk); sck_i = 1'b1;
      repeat (HP) @(negedge clk); sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk("R10 no flag before timeout", tmo_flag, 0);
    repeat (40) @(negedge clk);
    chk("R10 flag after stall", tmo_flag, 1);
    tmo_clr = 1'b1; @(negedge clk); tmo_clr = 1'b0;
    bm_byte(8'hC3, got);
    chk("R10 count realigned", rx_data, 8'hC3);
    tmo_clr = 1'b1; @(negedge clk); tmo_clr = 1'b0;
    repeat (40) @(negedge clk);
    chk("R11 flag on unread data", tmo_flag, 1);
    cfg_tmo = 8'd0;
    tmo_clr = 1'b1; @(negedge clk); tmo_clr = 1'b0;
    repeat (60) @(negedge clk);
    chk("R11 disabled at zero", tmo_flag, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk("watchdog", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule